// File: doc/BRIEF.md
# T1 Receive Alarm Detector

This block sits after the framer on the receive side of a DS1 line and watches the decoded bit stream for the far end's alarm signals. It raises three level flags. The superframe yellow flag means the far end is zeroing bit 2 of every channel. The ESF yellow flag means the facility data link carries an alternating run of eight ones and eight zeros. The blue flag reports an all-ones (AIS) signal seen while the framer is out of frame. A status-word serializer elsewhere samples the flags.

The clock runs at the bit rate, so each cycle carries one received bit. The framer marks the framing bit of each frame with `frameStrobe` and the first bit of each channel with `chanStart`. In ESF mode it marks data-link bits with `fdlValid`. The framer also supplies its out-of-frame flag. The yellow detector that matches the selected framing mode is active, and the other is held clear.

Top module: `t1_alarm_detect`

## Requirements
- R1: Channel bits are numbered 1 to 8 from the bit where `chanStart` is high, so bit 2 is the cycle after `chanStart`. In superframe mode (`esfMode`=0), `sfYellow` goes to 1 in the cycle after a `frameStrobe` if bit 2 of every channel since the previous `frameStrobe` was 0.
- R2: `sfYellow` changes only in the cycle after a `frameStrobe`. It returns to 0 at the first frame boundary that follows a frame in which any channel's bit 2 was 1.
- R3: While `esfMode`=1, `sfYellow` is 0 from the next cycle onward. While `esfMode`=0, `esfYellow` is 0 from the next cycle onward, and the data-link history is discarded.
- R4: In ESF mode, `esfYellow` goes to 1 in the cycle after the `fdlValid` bit that completes eight ones followed by eight zeros, counted over the last sixteen data-link bits (oldest first).
- R5: `esfYellow` changes only on `fdlValid` cycles or on a mode change. It returns to 0 on the sixteenth consecutive data-link bit that does not complete the pattern.
- R6: `blueAlarm` goes to 1 in the cycle after the bit that completes a run of 386 consecutive ones (two 193-bit frames), provided `oofFlag` is high on that bit or on any later bit of the same run.
- R7: `blueAlarm` never rises while `oofFlag` is low, whatever the length of the ones run.
- R8: Starting at reset release, the stream is cut into back-to-back 386-bit intervals. `blueAlarm` returns to 0 in the cycle after the last bit of an interval that held at least one zero. Otherwise it holds, whatever `oofFlag` does.
- R9: A synchronous active-high `rst` clears all three flags by the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rxBit | input | 1 | Received data bit for this cycle |
| frameStrobe | input | 1 | High on the framing bit of each frame |
| chanStart | input | 1 | High on bit 1 of each channel |
| fdlValid | input | 1 | High when rxBit is a data-link bit (ESF) |
| oofFlag | input | 1 | Out-of-frame indication from the framer |
| esfMode | input | 1 | 1 = ESF framing, 0 = superframe framing |
| sfYellow | output | 1 | Superframe (bit 2) yellow alarm |
| esfYellow | output | 1 | ESF data-link yellow alarm |
| blueAlarm | output | 1 | All-ones (AIS) blue alarm |

## Verification
The bench builds the block with its default parameters: 24 channels of 8 bits, two-frame set and clear windows, and an 8-bit data-link run. The blue set threshold and the clearing interval are therefore the real 386 bits, and the ESF pattern needs the real sixteen data-link frames. This keeps the full-length ones run, the oof gating, an interval that ends on a zero, and the sixteenth-miss clear within a short run. The yellow detectors are also driven across mode switches taken at frame boundaries.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;

  // Strobes the control half hands to the datapath each bit period.
  typedef struct packed {
    logic yelBit;     // current bit is the yellow bit position of a channel
    logic frameEdge;  // current bit is the framing bit
    logic sfEnable;   // superframe yellow detector active
    logic fdlShift;   // shift current bit into the data-link matcher
    logic fdlReset;   // discard data-link history
    logic ivEnd;      // current bit closes a blue-clear interval
  } alarmStrobes_t;

endpackage

// File: rtl/t1_alarm_ctl.sv
module t1_alarm_ctl
  import t1_alarm_pkg::*;
#(
  parameter int BITS_PER_CHAN = 8,
  parameter int YEL_POS       = 2,
  parameter int CLEAR_BITS    = 386
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chanStart,
  input  logic          frameStrobe,
  input  logic          fdlValid,
  input  logic          esfMode,
  output alarmStrobes_t strobes
);

  localparam int POS_W  = $clog2(BITS_PER_CHAN + 2);
  localparam int IV_W   = $clog2(CLEAR_BITS);
  localparam logic [POS_W-1:0] POS_IDLE = POS_W'(BITS_PER_CHAN + 1);
  localparam logic [IV_W-1:0]  IV_LAST  = IV_W'(CLEAR_BITS - 1);

  logic [POS_W-1:0] posReg;
  logic [POS_W-1:0] curPos;
  logic [IV_W-1:0]  ivCnt;

  // Bit position inside the current channel; saturates at idle past bit 8.
  always_comb begin
    if (chanStart)
      curPos = POS_W'(1);
    else if (posReg >= POS_IDLE)
      curPos = POS_IDLE;
    else
      curPos = posReg + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      posReg <= POS_IDLE;
    else
      posReg <= curPos;
  end

  // Free-running interval counter for blue clearing.
  always_ff @(posedge clk) begin
    if (rst)
      ivCnt <= '0;
    else if (ivCnt == IV_LAST)
      ivCnt <= '0;
    else
      ivCnt <= ivCnt + IV_W'(1);
  end

  always_comb begin
    strobes.yelBit    = (curPos == POS_W'(YEL_POS));
    strobes.frameEdge = frameStrobe;
    strobes.sfEnable  = ~esfMode;
    strobes.fdlShift  = fdlValid & esfMode;
    strobes.fdlReset  = ~esfMode;
    strobes.ivEnd     = (ivCnt == IV_LAST);
  end

endmodule

// File: rtl/t1_alarm_dp.sv
module t1_alarm_dp
  import t1_alarm_pkg::*;
#(
  parameter int FDL_RUN  = 8,
  parameter int AIS_BITS = 386
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxBit,
  input  logic          oofFlag,
  input  alarmStrobes_t strobes,
  output logic          sfYellow,
  output logic          esfYellow,
  output logic          blueAlarm
);

  localparam int PAT_W  = 2 * FDL_RUN;
  localparam int MISS_W = $clog2(PAT_W + 1);
  localparam int RUN_W  = $clog2(AIS_BITS + 1);
  localparam logic [PAT_W-1:0]  PATTERN   = {{FDL_RUN{1'b1}}, {FDL_RUN{1'b0}}};
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(PAT_W - 1);
  localparam logic [RUN_W-1:0]  RUN_FULL  = RUN_W'(AIS_BITS);
  localparam logic [RUN_W-1:0]  RUN_NEAR  = RUN_W'(AIS_BITS - 1);

  // ---------------- superframe yellow ----------------
  logic bit2One;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit2One  <= 1'b1;
      sfYellow <= 1'b0;
    end else begin
      if (!strobes.sfEnable)
        sfYellow <= 1'b0;
      else if (strobes.frameEdge)
        sfYellow <= ~bit2One;

      if (strobes.frameEdge)
        bit2One <= 1'b0;
      else if (strobes.yelBit && rxBit)
        bit2One <= 1'b1;
    end
  end

  // ---------------- ESF data-link yellow ----------------
  logic [PAT_W-1:0]  fdlReg;
  logic [PAT_W-1:0]  fdlNext;
  logic [MISS_W-1:0] missCnt;
  logic              fdlMatch;

  assign fdlNext  = {fdlReg[PAT_W-2:0], rxBit};
  assign fdlMatch = (fdlNext == PATTERN);

  always_ff @(posedge clk) begin
    if (rst || strobes.fdlReset) begin
      fdlReg    <= '0;
      missCnt   <= '0;
      esfYellow <= 1'b0;
    end else if (strobes.fdlShift) begin
      fdlReg <= fdlNext;
      if (fdlMatch) begin
        esfYellow <= 1'b1;
        missCnt   <= '0;
      end else if (missCnt == MISS_LAST) begin
        esfYellow <= 1'b0;
        missCnt   <= '0;
      end else begin
        missCnt <= missCnt + MISS_W'(1);
      end
    end
  end

  // ---------------- blue (AIS) ----------------
  logic [RUN_W-1:0] runCnt;
  logic             zeroSeen;
  logic             setNow;
  logic             clrNow;

  assign setNow = rxBit && (runCnt >= RUN_NEAR) && oofFlag;
  assign clrNow = strobes.ivEnd && (zeroSeen || !rxBit);

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt    <= '0;
      zeroSeen  <= 1'b0;
      blueAlarm <= 1'b0;
    end else begin
      if (!rxBit)
        runCnt <= '0;
      else if (runCnt != RUN_FULL)
        runCnt <= runCnt + RUN_W'(1);

      if (strobes.ivEnd)
        zeroSeen <= 1'b0;
      else if (!rxBit)
        zeroSeen <= 1'b1;

      if (clrNow)
        blueAlarm <= 1'b0;
      else if (setNow)
        blueAlarm <= 1'b1;
    end
  end

endmodule

// File: rtl/t1_alarm_detect.sv
module t1_alarm_detect
  import t1_alarm_pkg::*;
#(
  parameter int CHANNELS      = 24,
  parameter int BITS_PER_CHAN = 8,
  parameter int YEL_POS       = 2,
  parameter int FDL_RUN       = 8,
  parameter int AIS_FRAMES    = 2,
  parameter int CLEAR_FRAMES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxBit,
  input  logic frameStrobe,
  input  logic chanStart,
  input  logic fdlValid,
  input  logic oofFlag,
  input  logic esfMode,
  output logic sfYellow,
  output logic esfYellow,
  output logic blueAlarm
);

  localparam int FRAME_BITS = CHANNELS * BITS_PER_CHAN + 1;
  localparam int AIS_BITS   = AIS_FRAMES * FRAME_BITS;
  localparam int CLEAR_BITS = CLEAR_FRAMES * FRAME_BITS;

  alarmStrobes_t strobes;

  t1_alarm_ctl #(
    .BITS_PER_CHAN(BITS_PER_CHAN),
    .YEL_POS      (YEL_POS),
    .CLEAR_BITS   (CLEAR_BITS)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .chanStart  (chanStart),
    .frameStrobe(frameStrobe),
    .fdlValid   (fdlValid),
    .esfMode    (esfMode),
    .strobes    (strobes)
  );

  t1_alarm_dp #(
    .FDL_RUN (FDL_RUN),
    .AIS_BITS(AIS_BITS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .rxBit    (rxBit),
    .oofFlag  (oofFlag),
    .strobes  (strobes),
    .sfYellow (sfYellow),
    .esfYellow(esfYellow),
    .blueAlarm(blueAlarm)
  );

endmodule

// File: rtl/t1_alarm_chk.sv
module t1_alarm_chk (
  input logic clk,
  input logic rst,
  input logic rxBit,
  input logic frameStrobe,
  input logic fdlValid,
  input logic oofFlag,
  input logic esfMode,
  input logic sfYellow,
  input logic esfYellow,
  input logic blueAlarm
);

  logic pastRst = 1'b0;
  always_ff @(posedge clk) pastRst <= rst;

  // R9
  always_ff @(posedge clk) begin
    if (pastRst) begin
      reset_clear_chk: assert (!sfYellow && !esfYellow && !blueAlarm)
        else $error("flags not clear after reset");
    end
  end

  // R3
  sf_off_in_esf_chk: assert property (@(posedge clk) disable iff (rst)
    esfMode |=> !sfYellow);

  // R3
  esf_off_in_sf_chk: assert property (@(posedge clk) disable iff (rst)
    !esfMode |=> !esfYellow);

  // R2
  sf_frame_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!frameStrobe && !esfMode) |=> $stable(sfYellow));

  // R5
  esf_strobe_only_chk: assert property (@(posedge clk) disable iff (rst)
    (esfMode && !fdlValid) |=> $stable(esfYellow));

  // R7
  blue_needs_oof_chk: assert property (@(posedge clk) disable iff (rst)
    (!blueAlarm && !oofFlag) |=> !blueAlarm);

  // R6
  blue_needs_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!blueAlarm && !rxBit) |=> !blueAlarm);

endmodule

bind t1_alarm_detect t1_alarm_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rxBit      (rxBit),
  .frameStrobe(frameStrobe),
  .fdlValid   (fdlValid),
  .oofFlag    (oofFlag),
  .esfMode    (esfMode),
  .sfYellow   (sfYellow),
  .esfYellow  (esfYellow),
  .blueAlarm  (blueAlarm)
);

// File: tb/t1_alarm_detect_tb.sv
`timescale 1ns/1ps
module t1_alarm_detect_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxBit = 1'b0, frameStrobe = 1'b0, chanStart = 1'b0, fdlValid = 1'b0;
  logic oofFlag = 1'b0, esfMode = 1'b0;
  logic sfYellow, esfYellow, blueAlarm;

  always #10 clk = ~clk;

  t1_alarm_detect u_dut (
    .clk(clk), .rst(rst), .rxBit(rxBit), .frameStrobe(frameStrobe),
    .chanStart(chanStart), .fdlValid(fdlValid), .oofFlag(oofFlag),
    .esfMode(esfMode), .sfYellow(sfYellow), .esfYellow(esfYellow),
    .blueAlarm(blueAlarm)
  );

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  // reference model state
  bit mSf = 0, mEsf = 0, mBlue = 0;
  bit seenOne = 1;
  bit hist[$];
  int miss = 0;
  int run = 0;
  int ivK = 0;
  bit zeroIv = 0;

  task automatic chk(input string tag, input logic got, input logic exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit histMatch();
    if (hist.size() != 16) return 0;
    for (int i = 0; i < 16; i++)
      if (hist[i] != (i < 8)) return 0;
    return 1;
  endfunction

  // One bit period: drive at negedge, update model, compare at next negedge.
  task automatic tick(input bit b, input bit fs, input bit cs, input bit fv, input bit yel);
    rxBit = b; frameStrobe = fs; chanStart = cs; fdlValid = fv;
    if (rst) begin
      mSf = 0; mEsf = 0; mBlue = 0; seenOne = 1; hist.delete();
      miss = 0; run = 0; ivK = 0; zeroIv = 0;
    end else begin
      // superframe yellow
      if (esfMode) mSf = 0;
      else if (fs) mSf = !seenOne;
      seenOne = fs ? 1'b0 : (seenOne | (yel & b));
      // ESF yellow
      if (!esfMode) begin
        hist.delete(); miss = 0; mEsf = 0;
      end else if (fv) begin
        hist.push_back(b);
        if (hist.size() > 16) void'(hist.pop_front());
        if (histMatch()) begin mEsf = 1; miss = 0; end
        else begin
          miss++;
          if (miss == 16) begin mEsf = 0; miss = 0; end
        end
      end
      // blue
      if (b) run++; else run = 0;
      if (ivK == 385 && (zeroIv || !b)) mBlue = 0;
      else if (b && run >= 386 && oofFlag) mBlue = 1;
      if (ivK == 385) begin zeroIv = 0; ivK = 0; end
      else begin zeroIv = zeroIv | !b; ivK++; end
    end
    @(negedge clk);
    chk("R1/R2/R3 sfYellow", sfYellow, mSf);
    chk("R3/R4/R5 esfYellow", esfYellow, mEsf);
    chk("R6/R7/R8 blueAlarm", blueAlarm, mBlue);
  endtask

  // kind: 0 random, 1 all ones, 2 bit2 zero everywhere, 3 bit2 zero except last channel
  task automatic sendFrame(input int kind, input bit fdlOn, input bit fdlBit);
    bit fb;
    fb = fdlOn ? fdlBit : ((kind == 1) ? 1'b1 : 1'($urandom % 2));
    tick(fb, 1, 0, fdlOn, 0);
    for (int ch = 0; ch < 24; ch++) begin
      for (int j = 1; j <= 8; j++) begin
        bit b;
        b = (kind == 1) ? 1'b1 : 1'($urandom % 2);
        if (j == 2 && (kind == 2 || kind == 3)) b = 0;
        if (j == 2 && kind == 3 && ch == 23) b = 1;
        tick(b, 0, j == 1, 0, j == 2);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    repeat (3) tick(0, 0, 0, 0, 0);
    // R9 reset state
    chk("R9 sfYellow reset", sfYellow, 0);
    chk("R9 esfYellow reset", esfYellow, 0);
    chk("R9 blueAlarm reset", blueAlarm, 0);
    rst = 0;

    // superframe yellow
    esfMode = 0; oofFlag = 0;
    repeat (3) sendFrame(0, 0, 0);
    chk("R1 no yellow on random data", sfYellow, 0);
    repeat (2) sendFrame(2, 0, 0);
    sendFrame(3, 0, 0);
    chk("R1 sfYellow set after zero bit2 frames", sfYellow, 1);
    sendFrame(0, 0, 0);
    chk("R2 sfYellow cleared by bit2 one", sfYellow, 0);

    // ESF mode
    esfMode = 1;
    repeat (3) sendFrame(2, 1, 0);
    chk("R3 sfYellow held low in ESF", sfYellow, 0);
    for (int i = 0; i < 32; i++) sendFrame(0, 1, i % 16 < 8);
    chk("R4 esfYellow set by pattern", esfYellow, 1);
    repeat (15) sendFrame(0, 1, 0);
    chk("R5 esfYellow held before 16th miss", esfYellow, 1);
    sendFrame(0, 1, 0);
    chk("R5 esfYellow cleared on 16th miss", esfYellow, 0);
    for (int i = 0; i < 16; i++) sendFrame(0, 1, i < 8);
    chk("R4 esfYellow set again", esfYellow, 1);
    esfMode = 0;
    sendFrame(0, 0, 0);
    chk("R3 esfYellow cleared in superframe mode", esfYellow, 0);

    // blue
    oofFlag = 0;
    repeat (3) sendFrame(1, 0, 0);
    chk("R7 no blue without oof", blueAlarm, 0);
    oofFlag = 1;
    sendFrame(1, 0, 0);
    chk("R6 blue set with oof and ones", blueAlarm, 1);
    oofFlag = 0;
    repeat (3) sendFrame(1, 0, 0);
    chk("R8 blue held while all ones", blueAlarm, 1);
    repeat (3) sendFrame(0, 0, 0);
    chk("R8 blue cleared by zero interval", blueAlarm, 0);
    oofFlag = 1;
    repeat (3) sendFrame(0, 0, 0);
    chk("R6 no blue on random data", blueAlarm, 0);
    rst = 1;
    tick(1, 0, 0, 0, 0);
    rst = 0;
    chk("R9 flags clear after mid-run reset", blueAlarm | sfYellow | esfYellow, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule